// File: doc/BRIEF.md
# Parity Bus Transceiver with Error Register

This block bridges an 8-bit A bus and a 9-bit B bus whose ninth bit carries parity. Two active-low enables pick the direction. With the A-to-B direction active, the block copies the A byte onto B and adds a parity bit so that the nine-bit word holds an odd number of ones. With the B-to-A direction active, it copies the B byte onto A and checks the received nine-bit word. Both enables high isolates the buses. Both enables low drives B from A with the parity bit inverted, which deliberately creates a bad word for diagnostics.

The parity check feeds a flag register that loads on the rising clock edge whenever a direction is active and holds its value while the buses are isolated. The word checked is the one on the B bus: the received word in B-to-A mode, and the block's own driven word in the A-to-B modes. In the inverted mode, this loopback therefore records an error. An active-low clear resets the flag asynchronously. The flag leaves through a low-true error output with an open-drain style enable. Each tristate pad is modelled as separate in, out and output-enable signals.

Top module: `parity_xcvr`

## Requirements
- R1: With aEnN=1 and bEnN=0, bOe=1 and aOe=0, bOut equals aIn, and {bOut,bParOut} holds an odd number of ones.
- R2: With aEnN=0 and bEnN=0, bOe=1 and aOe=0, bOut equals aIn, and {bOut,bParOut} holds an even number of ones (inverted parity).
- R3: With aEnN=0 and bEnN=1, aOe=1 and bOe=0, and aOut equals bIn.
- R4: With aEnN=1 and bEnN=1, aOe=0 and bOe=0 (buses isolated).
- R5: On a rising clk edge in B-to-A mode, the flag loads the check of {bIn,bParIn}: errN becomes 0 if that word has an even number of ones and 1 if it has an odd number. Any single flipped bit of a valid word therefore gives errN=0.
- R6: In the A-to-B modes, the flag loads the check of the driven word: errN=1 after a normal-parity edge and errN=0 after an inverted-parity edge. While isolated, errN holds across clock edges.
- R7: clrN=0 forces errN=1 at once, without a clock edge, and keeps it there across clock edges whatever the bus inputs are. After clrN=0 the flag reads as no error.
- R8: errOe is 1 exactly when errN is 0 (drive low on error, released otherwise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error-flag register |
| clrN | input | 1 | Asynchronous active-low clear of the error flag |
| aEnN | input | 1 | Active-low enable toward the A side |
| bEnN | input | 1 | Active-low enable toward the B side |
| aIn | input | 8 | Value sensed on the A pads |
| aOut | output | 8 | Value driven onto the A pads |
| aOe | output | 1 | Output enable of the A pads |
| bIn | input | 8 | Data sensed on the B pads |
| bParIn | input | 1 | Parity bit sensed on the B pads |
| bOut | output | 8 | Data driven onto the B pads |
| bParOut | output | 1 | Parity bit driven onto the B pads |
| bOe | output | 1 | Output enable of the B pads (data and parity) |
| errN | output | 1 | Low-true registered parity error flag |
| errOe | output | 1 | Open-drain enable, high only while errN is low |

## Verification
The hardest state to reach from the ports is a clear that overlaps a capture. This needs a stored error and a bad word waiting on the B bus in the same clock period as clrN falling. The stimulus first records an error from a corrupted B word and then isolates the buses to hold the flag. It drops clrN between edges and checks errN immediately. With clrN still low, it applies a bad word in B-to-A mode across an edge, so the clear must win. Separately, the loopback capture in inverted mode is reached only by sweeping the A bus in that mode and reading the flag after the last edge.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

  typedef struct packed {
    logic driveA;     // A pads driven from B
    logic driveB;     // B pads driven from A
    logic invertPar;  // flip the generated parity bit
    logic capture;    // load the error flag on this edge
  } xcvrStrobes_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import parity_xcvr_pkg::*;
(
  input  logic         aEnN,
  input  logic         bEnN,
  output xcvrStrobes_t strobes
);

  typedef enum logic [1:0] {
    MODE_DIAG = 2'b00,
    MODE_B2A  = 2'b01,
    MODE_A2B  = 2'b10,
    MODE_ISO  = 2'b11
  } xcvrMode_t;

  xcvrMode_t mode;

  always_comb begin
    mode = xcvrMode_t'({aEnN, bEnN});
    strobes = '0;
    unique case (mode)
      MODE_A2B: begin
        strobes.driveB  = 1'b1;
        strobes.capture = 1'b1;
      end
      MODE_DIAG: begin
        strobes.driveB    = 1'b1;
        strobes.invertPar = 1'b1;
        strobes.capture   = 1'b1;
      end
      MODE_B2A: begin
        strobes.driveA  = 1'b1;
        strobes.capture = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import parity_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clrN,
  input  xcvrStrobes_t      strobes,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              bParIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOe,
  output logic [DATA_W-1:0] bOut,
  output logic              bParOut,
  output logic              bOe,
  output logic              errN,
  output logic              errOe
);

  localparam int WORD_W = DATA_W + 1;

  logic              genPar;
  logic [WORD_W-1:0] chkWord;
  logic              chkErr;
  logic              errFlag;

  // Odd parity: the bit that makes the word's ones count odd.
  assign genPar = ~(^aIn) ^ strobes.invertPar;

  assign bOut    = aIn;
  assign bParOut = genPar;
  assign bOe     = strobes.driveB;
  assign aOut    = bIn;
  assign aOe     = strobes.driveA;

  // The checker looks at whatever is on the B bus, including our own drive.
  assign chkWord = strobes.driveB ? {genPar, aIn} : {bParIn, bIn};
  assign chkErr  = ~(^chkWord);

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                errFlag <= 1'b0;
    else if (strobes.capture) errFlag <= chkErr;
  end

  assign errN  = ~errFlag;
  assign errOe = errFlag;

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import parity_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              aEnN,
  input  logic              bEnN,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOe,
  input  logic [DATA_W-1:0] bIn,
  input  logic              bParIn,
  output logic [DATA_W-1:0] bOut,
  output logic              bParOut,
  output logic              bOe,
  output logic              errN,
  output logic              errOe
);

  xcvrStrobes_t strobes;

  xcvr_ctrl u_ctrl (
    .aEnN    (aEnN),
    .bEnN    (bEnN),
    .strobes (strobes)
  );

  xcvr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .clrN    (clrN),
    .strobes (strobes),
    .aIn     (aIn),
    .bIn     (bIn),
    .bParIn  (bParIn),
    .aOut    (aOut),
    .aOe     (aOe),
    .bOut    (bOut),
    .bParOut (bParOut),
    .bOe     (bOe),
    .errN    (errN),
    .errOe   (errOe)
  );

endmodule

// File: rtl/parity_xcvr_checker.sv
module parity_xcvr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              clrN,
  input logic              aEnN,
  input logic              bEnN,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] aOut,
  input logic              aOe,
  input logic [DATA_W-1:0] bIn,
  input logic              bParIn,
  input logic [DATA_W-1:0] bOut,
  input logic              bParOut,
  input logic              bOe,
  input logic              errN
);

  assert_a2b_odd_R1: assert property (@(posedge clk) disable iff (!clrN)
    (aEnN && !bEnN) |-> (bOe && !aOe && bOut == aIn && ^{bParOut, bOut}));

  assert_diag_even_R2: assert property (@(posedge clk) disable iff (!clrN)
    (!aEnN && !bEnN) |-> (bOe && !aOe && bOut == aIn && !(^{bParOut, bOut})));

  assert_b2a_drive_R3: assert property (@(posedge clk) disable iff (!clrN)
    (!aEnN && bEnN) |-> (aOe && !bOe && aOut == bIn));

  assert_isolate_R4: assert property (@(posedge clk) disable iff (!clrN)
    (aEnN && bEnN) |-> (!aOe && !bOe));

  assert_b2a_capture_R5: assert property (@(posedge clk) disable iff (!clrN)
    (!aEnN && bEnN) |=> (errN == $past(^{bParIn, bIn})));

  assert_iso_hold_R6: assert property (@(posedge clk) disable iff (!clrN)
    (aEnN && bEnN) |=> $stable(errN));

endmodule

bind parity_xcvr parity_xcvr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .clrN(clrN), .aEnN(aEnN), .bEnN(bEnN), .aIn(aIn), .aOut(aOut),
  .aOe(aOe), .bIn(bIn), .bParIn(bParIn), .bOut(bOut), .bParOut(bParOut),
  .bOe(bOe), .errN(errN)
);

// File: tb/parity_xcvr_bench.sv
`timescale 1ns/100ps
module parity_xcvr_bench;

  logic       clk = 1'b0;
  logic       clrN, aEnN, bEnN, bParIn;
  logic [7:0] aIn, bIn;
  logic [7:0] aOut, bOut;
  logic       aOe, bOe, bParOut, errN, errOe;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  parity_xcvr u_parity_xcvr (
    .clk(clk), .clrN(clrN), .aEnN(aEnN), .bEnN(bEnN),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bParIn(bParIn), .bOut(bOut), .bParOut(bParOut), .bOe(bOe),
    .errN(errN), .errOe(errOe)
  );

  // {bIn, bParIn, expected errN} for B-to-A captures
  localparam logic [9:0] VEC [8] = '{
    {8'h00, 1'b1, 1'b1}, {8'h00, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b1}, {8'hFF, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b1}, {8'h80, 1'b1, 1'b0},
    {8'hA5, 1'b1, 1'b1}, {8'h3C, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkErr(input string req, input logic exp);
    check(errN === exp, req, int'(errN), int'(exp));
    check(errOe === !exp, "R8", int'(errOe), int'(!exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    clrN = 1'b0; aEnN = 1'b1; bEnN = 1'b1; aIn = '0; bIn = '0; bParIn = 1'b0;
    #1;
    checkErr("R7 reset", 1'b1);
    check(!aOe && !bOe, "R4 reset", int'({aOe, bOe}), 0);
    @(negedge clk); clrN = 1'b1;

    // R1 / R2: sweep all A values in both parity modes
    for (int m = 0; m < 2; m++) begin
      aEnN = (m == 0);
      bEnN = 1'b0;
      for (int v = 0; v < 256; v++) begin
        @(negedge clk);
        aIn = 8'(v);
        #1;
        if (m == 0)
          check(bOe && !aOe && bOut == aIn && $countones({bParOut, bOut}) % 2 == 1,
                "R1", int'({bOe, aOe, bParOut, bOut}), int'({2'b10, ~(^aIn), aIn}));
        else
          check(bOe && !aOe && bOut == aIn && $countones({bParOut, bOut}) % 2 == 0,
                "R2", int'({bOe, aOe, bParOut, bOut}), int'({2'b10, ^aIn, aIn}));
      end
      @(negedge clk);
      checkErr("R6 loopback", (m == 0) ? 1'b1 : 1'b0);
    end

    // R3 / R5: table of B-to-A captures
    aEnN = 1'b0; bEnN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {bIn, bParIn} = VEC[i][9:1];
      #1;
      check(aOe && !bOe && aOut == bIn, "R3", int'({aOe, bOe, aOut}), int'({2'b10, bIn}));
      @(negedge clk);
      checkErr("R5 table", VEC[i][0]);
    end

    // R5: single-bit errors injected into a valid word
    for (int b = 0; b < 9; b++) begin
      @(negedge clk);
      {bIn, bParIn} = {8'h5A, 1'b1} ^ (9'd1 << b);
      @(negedge clk);
      checkErr("R5 single-bit", 1'b0);
      {bIn, bParIn} = {8'h5A, 1'b1};
      @(negedge clk);
      checkErr("R5 valid", 1'b1);
    end

    // R4 / R6: store an error, then isolate and hold
    {bIn, bParIn} = {8'h5A, 1'b0};
    @(negedge clk);
    aEnN = 1'b1; bEnN = 1'b1;
    {bIn, bParIn} = {8'h5A, 1'b1};
    #1;
    check(!aOe && !bOe, "R4", int'({aOe, bOe}), 0);
    repeat (3) @(negedge clk);
    checkErr("R6 hold", 1'b0);

    // R7: asynchronous clear between edges, priority over a bad capture
    #1; clrN = 1'b0;
    #0.5;
    checkErr("R7 async", 1'b1);
    aEnN = 1'b0; bEnN = 1'b1; {bIn, bParIn} = {8'h0F, 1'b0};
    @(negedge clk);
    checkErr("R7 priority", 1'b1);
    clrN = 1'b1;
    @(negedge clk);
    checkErr("R5 after clear", 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule